// File: doc/BRIEF.md
# Processor Mode Status Derivation

This block holds an 18-bit status word that summarises the processor's operating state. A core reads it instead of decoding several control registers again for every instruction. The word carries the mode and submode, the current privilege level, whether paging and protection are on, and the log2 byte counts for the default and alternate operand sizes, the default and alternate address sizes, and the stack width.

The block keeps its own copies of the few source fields it needs. These come from the extended-feature register, control register 0, the code-segment and stack-segment attributes, and the flags register. Each source has its own write strobe. When any strobe is high, the word is rebuilt from the merged source values and registered. Decode logic can then use the size codes as they stand. A write aimed at the status word itself throws its data away and only rebuilds the word from the sources as they are.

Top module: `mode_status_unit`

## Requirements
- R1: Reset loads the word for all-zero sources, 0x19908. The field positions are: mode bit 0, submode bits 3:1, privilege bits 5:4, paging bit 6, protection bit 7, default operand size 9:8, alternate operand size 11:10, default address size 13:12, alternate address size 15:14, stack size 17:16.
- R2: When the long-active bit is set, mode is 1. The submode is 0 (64-bit) if the code-segment long bit is set, and 1 (compatibility) if it is clear.
- R3: When the long-active bit is clear, mode is 0. The submode is then 4 (real) with protection off, 3 (virtual-8086) with protection on and the flags V86 bit set, and 2 (protected) otherwise.
- R4: The privilege field equals the code-segment privilege. The paging and protection bits equal the control register 0 paging and protection-enable bits.
- R5: Size codes are 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Operand size is default 2 and alternate 1 in submode 0 or when the code-segment default-size bit is set. Otherwise it is default 1 and alternate 2.
- R6: Address size is default 3 and alternate 2 in submode 0. Outside submode 0 it is 2/1 when the code-segment default-size bit is set and 1/2 when it is clear.
- R7: Stack size is 3 in submode 0, 2 when the stack-segment default-size bit is set, and 1 otherwise.
- R8: The rebuilt word appears on the clock edge that samples the write strobe. Strobes that arrive in the same cycle are all merged into one result.
- R9: A write to the status word ignores its data and leaves the word equal to the value derived from the current sources.
- R10: Source fields that change while their strobe is low have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_wr | input | 1 | Extended-feature register write strobe |
| ext_long_act | input | 1 | Long-mode-active bit |
| ctl_wr | input | 1 | Control register 0 write strobe |
| ctl_paging | input | 1 | Paging enable |
| ctl_protect | input | 1 | Protection enable |
| code_wr | input | 1 | Code-segment attribute write strobe |
| code_long | input | 1 | Code-segment long bit |
| code_dsz | input | 1 | Code-segment default-size bit |
| code_dpl | input | 2 | Code-segment privilege level |
| stk_wr | input | 1 | Stack-segment attribute write strobe |
| stk_dsz | input | 1 | Stack-segment default-size bit |
| flg_wr | input | 1 | Flags register write strobe |
| flg_v86 | input | 1 | Virtual-8086 flag |
| sw_wr | input | 1 | Direct status-word write strobe |
| sw_data | input | 18 | Data of the direct write (discarded) |
| mode_word | output | 18 | Packed status word |

## Verification
Each result is due exactly one clock after its stimulus: strobes and fields are sampled on an edge, and the rebuilt word is already on the output when that edge settles. The bench drives inputs just after a falling edge and lets the next rising edge pass. Only then does it apply the same write to its reference copy of the sources, and it compares the output at the following falling edge, so every comparison has exactly one register in its path. Cycles with no strobe, cycles with a direct status-word write, and source changes without a strobe are compared in the same way, which proves the word holds its value.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int CPL_W  = 2;
  localparam int SZ_W   = 2;
  localparam int SUB_W  = 3;
  localparam int WORD_W = 1 + SUB_W + CPL_W + 2 + 5 * SZ_W;

  localparam logic [SZ_W-1:0] SZ16 = SZ_W'(1);
  localparam logic [SZ_W-1:0] SZ32 = SZ_W'(2);
  localparam logic [SZ_W-1:0] SZ64 = SZ_W'(3);

  typedef enum logic [SUB_W-1:0] {
    SUB_64     = 3'd0,
    SUB_COMPAT = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_V86    = 3'd3,
    SUB_REAL   = 3'd4
  } submode_e;

  typedef struct packed {
    logic             long_act;
    logic             paging;
    logic             protect;
    logic             code_long;
    logic             code_dsz;
    logic [CPL_W-1:0] dpl;
    logic             stk_dsz;
    logic             v86;
  } src_t;

  // packed from MSB down: bit 0 is mode
  typedef struct packed {
    logic [SZ_W-1:0]  stack;
    logic [SZ_W-1:0]  alt_addr;
    logic [SZ_W-1:0]  def_addr;
    logic [SZ_W-1:0]  alt_op;
    logic [SZ_W-1:0]  def_op;
    logic             prot;
    logic             paging;
    logic [CPL_W-1:0] cpl;
    submode_e         submode;
    logic             mode;
  } word_t;

  function automatic submode_e f_submode(input src_t s);
    if (s.long_act)     return s.code_long ? SUB_64 : SUB_COMPAT;
    else if (!s.protect) return SUB_REAL;
    else if (s.v86)      return SUB_V86;
    else                 return SUB_PROT;
  endfunction

  // returns {default, alternate}
  function automatic logic [2*SZ_W-1:0] f_op(input logic is64, input logic dsz);
    return (is64 || dsz) ? {SZ32, SZ16} : {SZ16, SZ32};
  endfunction

  function automatic logic [2*SZ_W-1:0] f_addr(input logic is64, input logic dsz);
    if (is64)     return {SZ64, SZ32};
    else if (dsz) return {SZ32, SZ16};
    else          return {SZ16, SZ32};
  endfunction

  function automatic logic [SZ_W-1:0] f_stack(input logic is64, input logic dsz);
    if (is64)     return SZ64;
    else if (dsz) return SZ32;
    else          return SZ16;
  endfunction

  function automatic word_t f_derive(input src_t s);
    word_t w;
    logic  is64;
    w.mode    = s.long_act;
    w.submode = f_submode(s);
    is64      = (w.submode == SUB_64);
    w.cpl     = s.dpl;
    w.paging  = s.paging;
    w.prot    = s.protect;
    {w.def_op, w.alt_op}     = f_op(is64, s.code_dsz);
    {w.def_addr, w.alt_addr} = f_addr(is64, s.code_dsz);
    w.stack   = f_stack(is64, s.stk_dsz);
    return w;
  endfunction

  localparam word_t RESET_WORD = f_derive('0);
endpackage

// File: rtl/mss_src_regs.sv
module mss_src_regs
  import mss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_wr,
  input  logic             ext_long_act,
  input  logic             ctl_wr,
  input  logic             ctl_paging,
  input  logic             ctl_protect,
  input  logic             code_wr,
  input  logic             code_long,
  input  logic             code_dsz,
  input  logic [CPL_W-1:0] code_dpl,
  input  logic             stk_wr,
  input  logic             stk_dsz,
  input  logic             flg_wr,
  input  logic             flg_v86,
  output src_t             nxt_o
);
  src_t cur_q;

  // merged view: newly written fields replace stored ones in the same cycle
  always_comb begin
    nxt_o = cur_q;
    if (ext_wr) nxt_o.long_act = ext_long_act;
    if (ctl_wr) begin
      nxt_o.paging  = ctl_paging;
      nxt_o.protect = ctl_protect;
    end
    if (code_wr) begin
      nxt_o.code_long = code_long;
      nxt_o.code_dsz  = code_dsz;
      nxt_o.dpl       = code_dpl;
    end
    if (stk_wr) nxt_o.stk_dsz = stk_dsz;
    if (flg_wr) nxt_o.v86     = flg_v86;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt_o;
  end
endmodule

// File: rtl/mss_derive.sv
module mss_derive
  import mss_pkg::*;
(
  input  src_t  src_i,
  output word_t word_o,
  output logic  is64_o
);
  assign word_o = f_derive(src_i);
  assign is64_o = src_i.long_act & src_i.code_long;
endmodule

// File: rtl/mss_status_reg.sv
module mss_status_reg
  import mss_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_i,
  input  logic  is64_i,
  input  word_t nxt_i,
  output word_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RESET_WORD;
    else if (upd_i) q_o <= nxt_i;
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(q_o));

  // R2
  long_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o.mode |-> (q_o.submode == SUB_64 || q_o.submode == SUB_COMPAT));

  // R3
  legacy_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_o.mode |-> (q_o.submode == SUB_PROT || q_o.submode == SUB_V86 ||
                   q_o.submode == SUB_REAL));

  // R3
  real_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o.submode == SUB_REAL) |-> !q_o.prot);

  // R7
  wide_sizes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && is64_i) |=> (q_o.stack == SZ64 && q_o.def_addr == SZ64 &&
                           q_o.def_op == SZ32));
endmodule

// File: rtl/mode_status_unit.sv
module mode_status_unit
  import mss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr,
  input  logic              ext_long_act,
  input  logic              ctl_wr,
  input  logic              ctl_paging,
  input  logic              ctl_protect,
  input  logic              code_wr,
  input  logic              code_long,
  input  logic              code_dsz,
  input  logic [1:0]        code_dpl,
  input  logic              stk_wr,
  input  logic              stk_dsz,
  input  logic              flg_wr,
  input  logic              flg_v86,
  input  logic              sw_wr,
  input  logic [17:0]       sw_data,
  output logic [17:0]       mode_word
);
  src_t  src_nxt;
  word_t word_nxt;
  word_t word_q;
  logic  is64_nxt;
  logic  src_any_wr;
  logic  recompute;
  logic  sw_data_unused;

  assign src_any_wr     = ext_wr | ctl_wr | code_wr | stk_wr | flg_wr;
  assign recompute      = src_any_wr | sw_wr;
  assign sw_data_unused = ^sw_data;

  mss_src_regs u_src (
    .clk, .rst_n,
    .ext_wr, .ext_long_act,
    .ctl_wr, .ctl_paging, .ctl_protect,
    .code_wr, .code_long, .code_dsz, .code_dpl,
    .stk_wr, .stk_dsz,
    .flg_wr, .flg_v86,
    .nxt_o(src_nxt)
  );

  mss_derive u_derive (
    .src_i(src_nxt),
    .word_o(word_nxt),
    .is64_o(is64_nxt)
  );

  mss_status_reg u_word (
    .clk, .rst_n,
    .upd_i(recompute),
    .is64_i(is64_nxt),
    .nxt_i(word_nxt),
    .q_o(word_q)
  );

  assign mode_word = word_q;

  // R4
  cpl_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> mode_word[5:4] == $past(code_dpl));

  // R4
  ctl_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (mode_word[6] == $past(ctl_paging) &&
                mode_word[7] == $past(ctl_protect)));

  // R9
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !src_any_wr) |=> $stable(mode_word));

  // R2
  long_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |=> mode_word[0] == $past(ext_long_act));
endmodule

// File: tb/mode_status_unit_tb.sv
module mode_status_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_wr, ext_long_act, ctl_wr, ctl_paging, ctl_protect;
  logic code_wr, code_long, code_dsz;
  logic [1:0] code_dpl;
  logic stk_wr, stk_dsz, flg_wr, flg_v86, sw_wr;
  logic [17:0] sw_data;
  logic [17:0] mode_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference copies of the source fields
  int m_lma, m_pg, m_pe, m_cl, m_cd, m_dpl, m_sd, m_vm;

  always #10 clk = ~clk;

  mode_status_unit u_dut (
    .clk, .rst_n, .ext_wr, .ext_long_act, .ctl_wr, .ctl_paging, .ctl_protect,
    .code_wr, .code_long, .code_dsz, .code_dpl, .stk_wr, .stk_dsz,
    .flg_wr, .flg_v86, .sw_wr, .sw_data, .mode_word
  );

  function automatic int ref_word();
    int sub, dop, aop, dad, aad, stk;
    if (m_lma != 0) sub = (m_cl != 0) ? 0 : 1;
    else if (m_pe == 0) sub = 4;
    else sub = (m_vm != 0) ? 3 : 2;
    if (sub == 0 || m_cd != 0) begin dop = 2; aop = 1; end
    else begin dop = 1; aop = 2; end
    if (sub == 0) begin dad = 3; aad = 2; end
    else if (m_cd != 0) begin dad = 2; aad = 1; end
    else begin dad = 1; aad = 2; end
    stk = (sub == 0) ? 3 : (m_sd != 0) ? 2 : 1;
    return m_lma + sub * 2 + m_dpl * 16 + m_pg * 64 + m_pe * 128 +
           dop * 256 + aop * 1024 + dad * 4096 + aad * 16384 + stk * 65536;
  endfunction

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(mode_word) != exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", tag, mode_word, exp[17:0]);
    end
  endtask

  task automatic idle_inputs();
    ext_wr = 0; ctl_wr = 0; code_wr = 0; stk_wr = 0; flg_wr = 0; sw_wr = 0;
  endtask

  // one clock: edge, model update, compare at falling edge
  task automatic cycle(input string tag);
    @(posedge clk);
    if (ext_wr)  m_lma = int'(ext_long_act);
    if (ctl_wr)  begin m_pg = int'(ctl_paging); m_pe = int'(ctl_protect); end
    if (code_wr) begin m_cl = int'(code_long); m_cd = int'(code_dsz); m_dpl = int'(code_dpl); end
    if (stk_wr)  m_sd = int'(stk_dsz);
    if (flg_wr)  m_vm = int'(flg_v86);
    @(negedge clk);
    check(tag, ref_word());
    idle_inputs();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    ext_long_act = 0; ctl_paging = 0; ctl_protect = 0; code_long = 0;
    code_dsz = 0; code_dpl = 0; stk_dsz = 0; flg_v86 = 0; sw_data = 0;
    m_lma = 0; m_pg = 0; m_pe = 0; m_cl = 0; m_cd = 0; m_dpl = 0; m_sd = 0; m_vm = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 'h19908);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 'h19908);

    // R3: protected, then virtual-8086, then real
    ctl_wr = 1; ctl_protect = 1; cycle("R3 protected");
    flg_wr = 1; flg_v86 = 1;     cycle("R3 v86");
    ctl_wr = 1; ctl_protect = 0; cycle("R3 real");
    flg_wr = 1; flg_v86 = 0;     cycle("R3 v86 cleared");

    // R5 R6: 32-bit code segment in protected mode
    ctl_wr = 1; ctl_protect = 1; code_wr = 1; code_dsz = 1; code_dpl = 2;
    cycle("R5 R6 32-bit default");
    stk_wr = 1; stk_dsz = 1; cycle("R7 32-bit stack");

    // R8: several strobes in one cycle give the 64-bit word
    ext_wr = 1; ext_long_act = 1; ctl_wr = 1; ctl_paging = 1; ctl_protect = 1;
    code_wr = 1; code_long = 1; code_dsz = 0; code_dpl = 3;
    stk_wr = 1; stk_dsz = 0;
    cycle("R8 merged writes");
    check("R2 R4 R5 R6 R7 64-bit word", 'h3B6F1);

    code_wr = 1; code_long = 0; code_dsz = 0; code_dpl = 0;
    cycle("R2 compatibility");

    // R10: fields move without strobes
    ext_long_act = 0; ctl_paging = 0; code_long = 1; code_dpl = 1;
    stk_dsz = 1; flg_v86 = 1;
    cycle("R10 no strobe");
    cycle("R10 still held");

    // R9: direct write with arbitrary data
    sw_wr = 1; sw_data = 18'h3FFFF; cycle("R9 direct write ones");
    sw_wr = 1; sw_data = 18'h00000; cycle("R9 direct write zeros");

    // R1: reset again returns to real mode word
    rst_n = 0;
    @(negedge clk);
    m_lma = 0; m_pg = 0; m_pe = 0; m_cl = 0; m_cd = 0; m_dpl = 0; m_sd = 0; m_vm = 0;
    check("R1 re-reset", 'h19908);
    rst_n = 1;
    @(negedge clk);

    // R8: random strobe and field mix
    for (int i = 0; i < 3000; i++) begin
      ext_wr = 1'($urandom); ctl_wr = 1'($urandom); code_wr = 1'($urandom);
      stk_wr = 1'($urandom); flg_wr = 1'($urandom); sw_wr = 1'($urandom);
      ext_long_act = 1'($urandom); ctl_paging = 1'($urandom);
      ctl_protect = 1'($urandom); code_long = 1'($urandom);
      code_dsz = 1'($urandom); code_dpl = 2'($urandom);
      stk_dsz = 1'($urandom); flg_v86 = 1'($urandom);
      sw_data = 18'($urandom);
      cycle("R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule